// File: doc/BRIEF.md
# Event and Cycle Counting Monitor

This block counts hardware events so that software can measure activity over a sampling window. It has a parameterised number of 32-bit event counters and one free-running cycle counter. Each event counter takes its pulses from one of a set of event input lines, chosen by a small selector register. Software reaches every register through a plain register port: an address, a write strobe and write data go in, and read data comes back from the same cycle's address.

A master enable gates all counting. Each counter also has its own enable, and there is one interrupt enable per counter. Both kinds of enable are changed through paired set-only and clear-only registers, so software never needs a read-modify-write. A counter that wraps from all ones to zero latches an overflow flag. A single level interrupt is raised while any flagged counter has its interrupt enabled.

The usual way to use the block is to preload a counter a fixed distance below the wrap point. The interrupt then fires after a chosen number of events.

Top module: `pmu_top`

## Requirements
- R1: After reset, every counter, every selector, the master enable, both enable bitmaps and the overflow flags read 0, and `irqOut` is low.
- R2: While bit 0 of the control register (offset 0x400) is 0, no counter changes except through a software write.
- R3: Writing to offset 0x403 sets the counter-enable bits that are 1 in the data. Writing to offset 0x402 clears the bits that are 1. Zero bits leave the state unchanged. Both offsets read back the current enable bitmap.
- R4: Interrupt enables behave the same way: offset 0x405 sets bits, offset 0x404 clears them, and both read the current bitmap.
- R5: An enabled event counter adds one on each clock where the master enable is set and its selected event line is high. The enabled cycle counter adds one on every such clock, with no event line.
- R6: Bits [3:0] of counter n's selector register (offset 0x424 + n*0x10) pick which of the 16 event lines it counts. The register reads back those 4 bits.
- R7: Counter n sits at offset 0x421 + n*0x10. When it wraps from 0xFFFFFFFF to 0, its overflow flag at bit n sets and counting carries on from 0.
- R8: Overflow flags read at offsets 0x406 and 0x407. Writing 1s to 0x406 clears the matching flags, and writing 1s to 0x407 sets them. A wrap in the same cycle as a clear leaves the flag set.
- R9: Counters are software writable. A write in the same cycle as an increment stores the written value. A counter preloaded with value V sets its flag on the (2^32 - V)-th event after that.
- R10: `irqOut` is high exactly while some bit is set in both the overflow flags and the interrupt enables.
- R11: In the enable, interrupt and overflow bitmaps, bits 0 to NUM_CNT-1 belong to the event counters and bit 31 to the cycle counter. All other bits read 0. Reads of unmapped offsets return 0.
- R12: The cycle counter is read and written at offset 0x409. A written value is visible on the next cycle and then advances by one per enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register offset |
| regWe | input | 1 | Write strobe for the addressed register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| evtIn | input | NUM_EVT | Event pulse lines, sampled each clock |
| irqOut | output | 1 | Level interrupt for enabled overflows |

## Verification
The bench builds the block with its defaults: four event counters, sixteen event lines and a 12-bit offset. With these values every selector code maps to a real line, and the bitmap gap between bit 3 and bit 31 can be tested for reading 0. Preloading counters close to all ones brings the full 32-bit wrap within a few cycles. This makes overflow, the same-cycle clash between a wrap and a clear, and the write-over-increment priority common under random stimulus.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int CYC_BIT = 31;

  // register offsets (software-visible map)
  localparam logic [11:0] OFS_CTL    = 12'h400;
  localparam logic [11:0] OFS_ENCLR  = 12'h402;
  localparam logic [11:0] OFS_ENSET  = 12'h403;
  localparam logic [11:0] OFS_IECLR  = 12'h404;
  localparam logic [11:0] OFS_IESET  = 12'h405;
  localparam logic [11:0] OFS_OVFCLR = 12'h406;
  localparam logic [11:0] OFS_OVFSET = 12'h407;
  localparam logic [11:0] OFS_CYC    = 12'h409;
  localparam logic [11:0] OFS_EVT    = 12'h420;
  localparam logic [3:0]  SUB_CNT    = 4'h1;
  localparam logic [3:0]  SUB_SEL    = 4'h4;

  typedef enum logic [2:0] {
    RS_NONE, RS_CTL, RS_EN, RS_IE, RS_OVF, RS_CYC, RS_CNT, RS_SEL
  } rdSrc_e;

  typedef struct packed {
    rdSrc_e     src;
    logic [4:0] idx;
  } rdSel_t;

  typedef struct packed {
    logic [DATA_W-1:0] wdata;
    logic              ctlWr;
    logic              enSet;
    logic              enClr;
    logic              ieSet;
    logic              ieClr;
    logic              ovfSet;
    logic              ovfClr;
    logic              cycWr;
    logic [31:0]       cntWr;
    logic [31:0]       selWr;
  } strobe_t;
endpackage

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output strobe_t           stb,
  output rdSel_t            rsel
);
  localparam int IDX_W = ADDR_W - 4;

  logic [ADDR_W-1:0] evtOff;
  logic [IDX_W-1:0]  evtIdx;
  logic [3:0]        sub;
  logic              inEvt;

  always_comb begin
    evtOff = addr - ADDR_W'(OFS_EVT);
    evtIdx = evtOff[ADDR_W-1:4];
    sub    = addr[3:0];
    inEvt  = (addr >= ADDR_W'(OFS_EVT)) && (int'(evtIdx) < NUM_CNT);
  end

  always_comb begin
    stb        = '0;
    stb.wdata  = wdata;
    rsel.src   = RS_NONE;
    rsel.idx   = 5'(evtIdx);
    if (addr == ADDR_W'(OFS_CTL)) begin
      rsel.src  = RS_CTL;
      stb.ctlWr = we;
    end else if (addr == ADDR_W'(OFS_ENSET)) begin
      rsel.src  = RS_EN;
      stb.enSet = we;
    end else if (addr == ADDR_W'(OFS_ENCLR)) begin
      rsel.src  = RS_EN;
      stb.enClr = we;
    end else if (addr == ADDR_W'(OFS_IESET)) begin
      rsel.src  = RS_IE;
      stb.ieSet = we;
    end else if (addr == ADDR_W'(OFS_IECLR)) begin
      rsel.src  = RS_IE;
      stb.ieClr = we;
    end else if (addr == ADDR_W'(OFS_OVFCLR)) begin
      rsel.src   = RS_OVF;
      stb.ovfClr = we;
    end else if (addr == ADDR_W'(OFS_OVFSET)) begin
      rsel.src   = RS_OVF;
      stb.ovfSet = we;
    end else if (addr == ADDR_W'(OFS_CYC)) begin
      rsel.src  = RS_CYC;
      stb.cycWr = we;
    end else if (inEvt && sub == SUB_CNT) begin
      rsel.src = RS_CNT;
      for (int i = 0; i < NUM_CNT; i++) stb.cntWr[i] = we && (int'(evtIdx) == i);
    end else if (inEvt && sub == SUB_SEL) begin
      rsel.src = RS_SEL;
      for (int i = 0; i < NUM_CNT; i++) stb.selWr[i] = we && (int'(evtIdx) == i);
    end
  end

  // R11: at most one register target is written per cycle
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ctlWr, stb.enSet, stb.enClr, stb.ieSet, stb.ieClr, stb.ovfSet,
              stb.ovfClr, stb.cycWr, |stb.cntWr, |stb.selWr}));
  p_cnt_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.cntWr) && $onehot0(stb.selWr));
  // R11: unmapped offsets produce no write strobe
  p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rsel.src == RS_NONE) |-> (stb.cntWr == '0 && !stb.cycWr && !stb.ctlWr));
endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  rdSel_t             rsel,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  localparam int          SEL_W = $clog2(NUM_EVT);
  localparam logic [31:0] IMPL  = (32'h1 << CYC_BIT) | ((32'h1 << NUM_CNT) - 32'h1);

  logic [NUM_CNT-1:0][DATA_W-1:0] cntQ;
  logic [NUM_CNT-1:0][SEL_W-1:0]  selQ;
  logic [DATA_W-1:0]              cycQ;
  logic                           ctlEnQ;
  logic [31:0]                    enQ, ieQ, ovfQ, ovfNext, wrapVec;
  logic [NUM_CNT-1:0]             incVec;
  logic                           cycInc;

  always_comb begin
    wrapVec = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      incVec[i]  = ctlEnQ && enQ[i] && evtIn[selQ[i]];
      wrapVec[i] = incVec[i] && !stb.cntWr[i] && (&cntQ[i]);
    end
    cycInc           = ctlEnQ && enQ[CYC_BIT];
    wrapVec[CYC_BIT] = cycInc && !stb.cycWr && (&cycQ);
    ovfNext = ((ovfQ & ~(stb.ovfClr ? stb.wdata : 32'h0))
               | (stb.ovfSet ? stb.wdata : 32'h0) | wrapVec) & IMPL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      selQ   <= '0;
      cycQ   <= '0;
      ctlEnQ <= 1'b0;
      enQ    <= '0;
      ieQ    <= '0;
      ovfQ   <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (stb.cntWr[i])    cntQ[i] <= stb.wdata;
        else if (incVec[i])  cntQ[i] <= cntQ[i] + 32'd1;
        if (stb.selWr[i])    selQ[i] <= stb.wdata[SEL_W-1:0];
      end
      if (stb.cycWr)         cycQ <= stb.wdata;
      else if (cycInc)       cycQ <= cycQ + 32'd1;
      if (stb.ctlWr)         ctlEnQ <= stb.wdata[0];
      if (stb.enSet)         enQ <= enQ | (stb.wdata & IMPL);
      else if (stb.enClr)    enQ <= enQ & ~stb.wdata;
      if (stb.ieSet)         ieQ <= ieQ | (stb.wdata & IMPL);
      else if (stb.ieClr)    ieQ <= ieQ & ~stb.wdata;
      ovfQ <= ovfNext;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rsel.src)
      RS_CTL:  rdData = {31'h0, ctlEnQ};
      RS_EN:   rdData = enQ;
      RS_IE:   rdData = ieQ;
      RS_OVF:  rdData = ovfQ;
      RS_CYC:  rdData = cycQ;
      RS_CNT:  for (int i = 0; i < NUM_CNT; i++) if (rsel.idx == 5'(i)) rdData = cntQ[i];
      RS_SEL:  for (int i = 0; i < NUM_CNT; i++) if (rsel.idx == 5'(i)) rdData = DATA_W'(selQ[i]);
      default: rdData = '0;
    endcase
  end

  assign irqOut = |(ovfQ & ieQ);

  // R3: set bits stick, quiet cycles leave the bitmap alone
  p_en_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> ((enQ & $past(stb.wdata) & IMPL) == ($past(stb.wdata) & IMPL)));
  p_en_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.enSet || stb.enClr) |=> $stable(enQ));
  // R4: clear bits drop
  p_ie_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.ieClr |=> ((ieQ & $past(stb.wdata)) == 32'h0));
  // R8: cleared flags stay clear unless a wrap hit them
  p_ovf_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.ovfClr |=> ((ovfQ & $past(stb.wdata) & ~$past(wrapVec)) == 32'h0));
  // R10: interrupt needs an enabled flag
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ieQ != 32'h0 && ovfQ != 32'h0));
  // R11: unimplemented bitmap bits never set
  p_bitmap_gap_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((enQ | ieQ | ovfQ) & ~IMPL) == 32'h0);
  // R12: cycle write visible next cycle
  p_cyc_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    stb.cycWr |=> (cycQ == $past(stb.wdata)));

  for (genvar g = 0; g < NUM_CNT; g++) begin : gChk
    // R2: master enable off holds counters
    p_hold_off_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!ctlEnQ && !stb.cntWr[g]) |=> $stable(cntQ[g]));
    // R7: wrap lands on zero with flag set
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
      (incVec[g] && !stb.cntWr[g] && (&cntQ[g])) |=> (cntQ[g] == '0 && ovfQ[g]));
    // R9: software write wins over an increment
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      stb.cntWr[g] |=> (cntQ[g] == $past(stb.wdata)));
  end
endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 16,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic              irqOut
);
  strobe_t stb;
  rdSel_t  rsel;

  pmu_ctrl #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(regAddr), .we(regWe), .wdata(regWdata),
    .stb(stb), .rsel(rsel)
  );

  pmu_datapath #(.NUM_CNT(NUM_CNT), .NUM_EVT(NUM_EVT)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .rsel(rsel), .evtIn(evtIn),
    .rdData(regRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_pmu_top.sv
module sim_pmu_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [15:0] evtIn = '0;
  logic        irqOut;

  int  nChk = 0;
  int  nFail = 0;
  bit  done = 0;

  localparam logic [31:0] IMPL = 32'h8000_000F;

  // reference model state
  logic        mEn = 1'b0;
  logic [31:0] mEnMask = '0, mIe = '0, mOvf = '0, mCyc = '0;
  logic [31:0] mCnt [4] = '{default: '0};
  logic [3:0]  mSel [4] = '{default: '0};

  always #2 clk = ~clk;

  pmu_top u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .evtIn(evtIn), .irqOut(irqOut)
  );

  function automatic logic [31:0] mRead(input logic [11:0] a);
    case (a)
      12'h400: return {31'h0, mEn};
      12'h402, 12'h403: return mEnMask;
      12'h404, 12'h405: return mIe;
      12'h406, 12'h407: return mOvf;
      12'h409: return mCyc;
      default: begin
        for (int i = 0; i < 4; i++) begin
          if (a == 12'h421 + 12'(i * 16)) return mCnt[i];
          if (a == 12'h424 + 12'(i * 16)) return {28'h0, mSel[i]};
        end
        return 32'h0;
      end
    endcase
  endfunction

  task automatic modelStep(input logic [11:0] a, input logic we, input logic [31:0] d,
                           input logic [15:0] ev);
    logic [31:0] wrap;
    logic        inc;
    wrap = '0;
    for (int i = 0; i < 4; i++) begin
      inc = mEn && mEnMask[i] && ev[mSel[i]];
      if (we && a == 12'h421 + 12'(i * 16)) mCnt[i] = d;
      else if (inc) begin
        if (mCnt[i] == 32'hFFFF_FFFF) wrap[i] = 1'b1;
        mCnt[i] = mCnt[i] + 32'd1;
      end
      if (we && a == 12'h424 + 12'(i * 16)) mSel[i] = d[3:0];
    end
    inc = mEn && mEnMask[31];
    if (we && a == 12'h409) mCyc = d;
    else if (inc) begin
      if (mCyc == 32'hFFFF_FFFF) wrap[31] = 1'b1;
      mCyc = mCyc + 32'd1;
    end
    if (we && a == 12'h400) mEn = d[0];
    if (we && a == 12'h403) mEnMask = mEnMask | (d & IMPL);
    if (we && a == 12'h402) mEnMask = mEnMask & ~d;
    if (we && a == 12'h405) mIe = mIe | (d & IMPL);
    if (we && a == 12'h404) mIe = mIe & ~d;
    if (we && a == 12'h406) mOvf = mOvf & ~d;
    if (we && a == 12'h407) mOvf = mOvf | d;
    mOvf = (mOvf | wrap) & IMPL;
  endtask

  // one clock: drive, compare before the edge, advance the model after it
  task automatic step(input logic [11:0] a, input logic we, input logic [31:0] d,
                      input logic [15:0] ev, input string tag,
                      input logic useLit, input logic [31:0] lit);
    logic [31:0] expv;
    logic        expIrq;
    @(negedge clk);
    regAddr = a; regWe = we; regWdata = d; evtIn = ev;
    #1;
    expv   = useLit ? lit : mRead(a);
    expIrq = |(mOvf & mIe);
    nChk++;
    if (regRdata !== expv) begin
      nFail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, regRdata, expv);
    end
    nChk++;
    if (irqOut !== expIrq) begin
      nFail++;
      $display("FAIL R10 irq at addr=%h actual=%b expected=%b", a, irqOut, expIrq);
    end
    @(posedge clk);
    modelStep(a, we, d, ev);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [15:0] ev);
    step(a, 1'b1, d, ev, "R3/R5 write", 1'b0, 32'h0);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    step(a, 1'b0, 32'h0, 16'h0, tag, 1'b1, e);
  endtask

  task automatic idle(input logic [15:0] ev);
    step(12'h400, 1'b0, 32'h0, ev, "R5 idle", 1'b0, 32'h0);
  endtask

  function automatic logic [11:0] pickAddr(input int k);
    logic [11:0] t [20] = '{12'h400, 12'h402, 12'h403, 12'h404, 12'h405, 12'h406,
                            12'h407, 12'h409, 12'h421, 12'h431, 12'h441, 12'h451,
                            12'h424, 12'h434, 12'h444, 12'h454, 12'h401, 12'h422,
                            12'h461, 12'h408};
    return t[k % 20];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [11:0] a;
    logic [31:0] d;
    logic        we;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(12'h400, 32'h0, "R1"); rd(12'h403, 32'h0, "R1"); rd(12'h405, 32'h0, "R1");
    rd(12'h406, 32'h0, "R1"); rd(12'h409, 32'h0, "R1"); rd(12'h421, 32'h0, "R1");
    rd(12'h454, 32'h0, "R1");

    // R2 master enable off: enabled counters hold
    wr(12'h403, 32'h8000_0001, 16'h0);
    rd(12'h403, 32'h8000_0001, "R3");
    idle(16'hFFFF); idle(16'hFFFF);
    rd(12'h421, 32'h0, "R2"); rd(12'h409, 32'h0, "R2");

    // R3 / R11 set, clear, zero bits, gap bits
    wr(12'h403, 32'hFFFF_FFFF, 16'h0);
    rd(12'h402, 32'h8000_000F, "R11");
    wr(12'h402, 32'h0000_000E, 16'h0);
    rd(12'h403, 32'h8000_0001, "R3");
    wr(12'h403, 32'h0, 16'h0);
    rd(12'h403, 32'h8000_0001, "R3");

    // R6 event selection
    wr(12'h424, 32'hFFFF_FFF5, 16'h0);
    rd(12'h424, 32'h5, "R6");
    wr(12'h400, 32'h1, 16'h0);
    idle(16'h0020); idle(16'h0020); idle(16'h0020);
    idle(16'h0010); idle(16'h0010);
    rd(12'h421, 32'h3, "R6");

    // R12 cycle counter write and advance
    wr(12'h409, 32'd100, 16'h0);
    rd(12'h409, 32'd100, "R12");
    rd(12'h409, 32'd101, "R12");

    // R7 wrap
    wr(12'h403, 32'h2, 16'h0);
    wr(12'h431, 32'hFFFF_FFFE, 16'h0);
    idle(16'h0001);
    rd(12'h406, 32'h0, "R7");
    idle(16'h0001);
    rd(12'h431, 32'h0, "R7");
    rd(12'h406, 32'h2, "R7");

    // R4 / R10 interrupt enables
    wr(12'h405, 32'h2, 16'h0);
    rd(12'h405, 32'h2, "R4");
    rd(12'h406, 32'h2, "R10");
    wr(12'h404, 32'h2, 16'h0);
    rd(12'h405, 32'h0, "R4");
    wr(12'h405, 32'h2, 16'h0);

    // R8 clear and set flags
    wr(12'h406, 32'h2, 16'h0);
    rd(12'h406, 32'h0, "R8");
    wr(12'h407, 32'h1, 16'h0);
    rd(12'h407, 32'h1, "R8");
    wr(12'h406, 32'hFFFF_FFFF, 16'h0);
    rd(12'h406, 32'h0, "R8");

    // R9 preload distance: V = FFFFFFFC flags on the 4th event
    wr(12'h431, 32'hFFFF_FFFC, 16'h0);
    idle(16'h0001); idle(16'h0001); idle(16'h0001);
    rd(12'h406, 32'h0, "R9");
    idle(16'h0001);
    rd(12'h406, 32'h2, "R9");
    wr(12'h406, 32'h2, 16'h0);

    // R9 write wins over simultaneous increment
    wr(12'h421, 32'h55, 16'h0020);
    rd(12'h421, 32'h55, "R9");

    // R11 unmapped offsets
    rd(12'h401, 32'h0, "R11"); rd(12'h422, 32'h0, "R11");
    rd(12'h408, 32'h0, "R11"); rd(12'h461, 32'h0, "R11");
    rd(12'h7FF, 32'h0, "R11");

    // R8 wrap beats a same-cycle clear
    wr(12'h431, 32'hFFFF_FFFF, 16'h0);
    wr(12'h406, 32'h2, 16'h0001);
    rd(12'h406, 32'h2, "R8");
    rd(12'h431, 32'h0, "R7");

    // constrained random phase, compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      a  = pickAddr(int'($urandom % 20));
      we = ($urandom % 3) == 0;
      d  = $urandom;
      if (a == 12'h400 && ($urandom % 10) != 0) d[0] = 1'b1;
      if (a == 12'h402 && ($urandom % 2) == 0) d = 32'h0;
      if ((a == 12'h409 || a[3:0] == 4'h1) && ($urandom % 2) == 0)
        d = 32'hFFFF_FFF0 | {28'h0, 4'($urandom)};
      if (a[3:0] == 4'h4 && a >= 12'h424) d = {28'h0, 4'($urandom % 4)};
      step(a, we, d, 16'($urandom), "R5/R7/R8 random", 1'b0, 32'h0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule